// File: doc/BRIEF.md
# Sticky Interrupt Flag Aggregator

This block collects the interrupt causes of an Ethernet controller into one flag register and drives one active-low interrupt request line to the host. There are six causes: receive overflow or abort, transmit abort, end of transmission, link state change, end of a DMA operation, and packets waiting in the receive buffer. Four of them are sticky. Each of these four is set by a datapath event and stays set until the host clears it through a bit-clear strobe.

End of transmission and end of DMA come from falling edges of the request and busy bits. A detector inside the block finds these edges. The link cause follows a latched change flag on the PHY side, but only while two PHY-side enables are both high. A read strobe of the PHY flag register wipes that latched flag. The packet cause is not stored. It is a level that is true whenever the pending-packet count is non-zero.

The host masks each cause with an enable bit and masks all of them with a global enable. The request line is registered, so it follows the masked flags one cycle later.

Top module: `irq_flag_agg`

## Requirements
- R1: After reset, `flags` is 0, `phy_flags` is 0, `int_n` is 1 and `int_active` is 0.
- R2: Let A be `glob_en` AND (OR over `flags & src_en`). When A is true at a clock edge, `int_n` is 0 after that edge. When A is false, `int_n` is 1 after that edge. This means `int_n` goes high one cycle after the last enabled flag, or its enable, is removed.
- R3: The flag bits that can be set and cleared are bit 0 (receive error), bit 1 (transmit error), bit 2 (transmit done) and bit 4 (DMA done). The same-numbered bit of `host_set` sets each of them, and it stays set until the same-numbered bit of `host_clr` is seen.
- R4: A 1-to-0 transition of `tx_req` sets bit 2 on the edge that samples the 0. A 0-to-1 transition sets nothing.
- R5: A 1-to-0 transition of `dma_busy` sets bit 4 on the edge that samples the 0.
- R6: A `tx_err_evt` pulse sets bit 1 and bit 2 on the same edge. A `rx_err_evt` pulse sets bit 0.
- R7: Bit 3 (link) equals the PHY-side latched link-change flag AND `phy_link_en` AND `phy_glob_en`. It is 0 whenever either enable is low. `phy_flags` is {bit 1: gated global flag, bit 0: latched link flag}, and `phy_link_evt` sets the latched link flag.
- R8: `phy_flag_rd` clears the latched link flag. This takes bit 3 of `flags` and both bits of `phy_flags` to 0 after that edge.
- R9: Bit 3 of `host_set` and bit 3 of `host_clr` have no effect on any flag.
- R10: Bit 5 (packet pending) is 1 exactly when `pend_count` is non-zero. Bit 5 of `host_clr` and bit 5 of `host_set` have no effect on it.
- R11: When a set source and the host clear of the same flag arrive on the same edge, the flag ends up set. This holds for both the sticky flags and the PHY link flag.
- R12: `int_active` is always the inverse of `int_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_err_evt | input | 1 | Receive overflow/abort event pulse |
| tx_err_evt | input | 1 | Transmit abort event pulse |
| tx_req | input | 1 | Transmit request control bit (level) |
| dma_busy | input | 1 | DMA start/busy control bit (level) |
| pend_count | input | CNT_W | Pending received packet count |
| phy_link_evt | input | 1 | PHY link change event pulse |
| phy_flag_rd | input | 1 | Read strobe of the PHY flag register |
| phy_link_en | input | 1 | PHY link interrupt enable |
| phy_glob_en | input | 1 | PHY global interrupt enable |
| host_set | input | 6 | Host bit-set strobes for the flag register |
| host_clr | input | 6 | Host bit-clear strobes for the flag register |
| src_en | input | 6 | Per-flag interrupt enables |
| glob_en | input | 1 | Global interrupt enable |
| flags | output | 6 | Flag register |
| phy_flags | output | 2 | PHY-side flags {global, link} |
| int_active | output | 1 | Status copy of the interrupt state |
| int_n | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block with `CNT_W` = 4. This keeps the pending count small, so the bench can set both zero and non-zero counts directly. The main sweep covers all 64 flag patterns, all 64 enable masks, and both states of the global enable. In every one of these cases, the bench compares `int_n` against a mask-and-reduce that it computes itself. Directed sequences then cover the edge detectors, same-edge set/clear conflicts, the two-enable link gating and the clear-on-read path.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int NFLAG    = 6;
  localparam int F_RXERR  = 0;
  localparam int F_TXERR  = 1;
  localparam int F_TXDONE = 2;
  localparam int F_LINK   = 3;
  localparam int F_DMA    = 4;
  localparam int F_PKT    = 5;
  localparam logic [NFLAG-1:0] STICKY_MASK = 6'b010111;

  // interrupt request: global enable and any enabled active flag
  function automatic logic irq_request(input logic [NFLAG-1:0] f,
                                       input logic [NFLAG-1:0] en,
                                       input logic glob);
    return glob & (|(f & en));
  endfunction

  // sticky update, set has priority over clear
  function automatic logic [NFLAG-1:0] sticky_next(input logic [NFLAG-1:0] cur,
                                                   input logic [NFLAG-1:0] set,
                                                   input logic [NFLAG-1:0] clr);
    return ((cur & ~clr) | set) & STICKY_MASK;
  endfunction
endpackage

// File: rtl/irq_fall_det.sv
module irq_fall_det #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] level,
  output logic [N-1:0] fall
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic prev_q;
    always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level[i];
    end
    assign fall[i] = prev_q & ~level[i];
  end
endmodule

// File: rtl/irq_phy_link.sv
module irq_phy_link (
  input  logic clk,
  input  logic rst_n,
  input  logic link_evt,
  input  logic flag_rd,
  input  logic link_en,
  input  logic glob_en,
  output logic plnk,
  output logic pgif
);
  logic plnk_q;
  always_ff @(posedge clk) begin
    if (!rst_n)        plnk_q <= 1'b0;
    else if (link_evt) plnk_q <= 1'b1;
    else if (flag_rd)  plnk_q <= 1'b0;
  end
  assign plnk = plnk_q;
  assign pgif = plnk_q & link_en & glob_en;
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_agg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] evt_set,
  input  logic [NFLAG-1:0] host_set,
  input  logic [NFLAG-1:0] host_clr,
  output logic [NFLAG-1:0] sticky
);
  logic [NFLAG-1:0] sticky_q;
  always_ff @(posedge clk) begin
    if (!rst_n) sticky_q <= '0;
    else        sticky_q <= sticky_next(sticky_q, evt_set | host_set, host_clr);
  end
  assign sticky = sticky_q;
endmodule

// File: rtl/irq_flag_agg.sv
module irq_flag_agg
  import irq_agg_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_err_evt,
  input  logic             tx_err_evt,
  input  logic             tx_req,
  input  logic             dma_busy,
  input  logic [CNT_W-1:0] pend_count,
  input  logic             phy_link_evt,
  input  logic             phy_flag_rd,
  input  logic             phy_link_en,
  input  logic             phy_glob_en,
  input  logic [5:0]       host_set,
  input  logic [5:0]       host_clr,
  input  logic [5:0]       src_en,
  input  logic             glob_en,
  output logic [5:0]       flags,
  output logic [1:0]       phy_flags,
  output logic             int_active,
  output logic             int_n
);
  localparam int NEDGE = 2;

  logic [NEDGE-1:0] edge_lvl, edge_fall;
  logic             tx_end_evt, dma_end_evt;
  logic [NFLAG-1:0] evt_set, sticky;
  logic             plnk, pgif, pkt_level, irq_req;
  logic             int_n_q;

  assign edge_lvl = {dma_busy, tx_req};

  irq_fall_det #(.N(NEDGE)) u_fall (
    .clk(clk), .rst_n(rst_n), .level(edge_lvl), .fall(edge_fall)
  );

  assign tx_end_evt  = edge_fall[0];
  assign dma_end_evt = edge_fall[1];

  always_comb begin
    evt_set           = '0;
    evt_set[F_RXERR]  = rx_err_evt;
    evt_set[F_TXERR]  = tx_err_evt;
    evt_set[F_TXDONE] = tx_err_evt | tx_end_evt;
    evt_set[F_DMA]    = dma_end_evt;
  end

  irq_flag_bank u_bank (
    .clk(clk), .rst_n(rst_n), .evt_set(evt_set),
    .host_set(host_set), .host_clr(host_clr), .sticky(sticky)
  );

  irq_phy_link u_phy (
    .clk(clk), .rst_n(rst_n), .link_evt(phy_link_evt), .flag_rd(phy_flag_rd),
    .link_en(phy_link_en), .glob_en(phy_glob_en), .plnk(plnk), .pgif(pgif)
  );

  assign pkt_level = |pend_count;

  always_comb begin
    flags         = sticky;
    flags[F_LINK] = pgif;
    flags[F_PKT]  = pkt_level;
  end

  assign irq_req = irq_request(flags, src_en, glob_en);

  always_ff @(posedge clk) begin
    if (!rst_n) int_n_q <= 1'b1;
    else        int_n_q <= ~irq_req;
  end

  assign int_n      = int_n_q;
  assign int_active = ~int_n_q;
  assign phy_flags  = {pgif, plnk};
endmodule

// File: rtl/irq_flag_agg_chk.sv
module irq_flag_agg_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_err_evt,
  input logic             tx_err_evt,
  input logic             tx_req,
  input logic             phy_link_evt,
  input logic             phy_flag_rd,
  input logic             phy_link_en,
  input logic             phy_glob_en,
  input logic [5:0]       host_clr,
  input logic [5:0]       src_en,
  input logic             glob_en,
  input logic [CNT_W-1:0] pend_count,
  input logic [5:0]       flags,
  input logic [1:0]       phy_flags,
  input logic             int_n
);
  a_r2_int_asserts: assert property (@(posedge clk) disable iff (!rst_n)
    (glob_en && ((flags & src_en) != 6'd0)) |=> !int_n);
  a_r2_int_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (!glob_en || ((flags & src_en) == 6'd0)) |=> int_n);
  a_r3_rx_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !host_clr[0]) |=> flags[0]);
  a_r4_tx_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_req) |-> ##0 1'b1 ##1 flags[2]);
  a_r6_txerr_both: assert property (@(posedge clk) disable iff (!rst_n)
    tx_err_evt |=> (flags[1] && flags[2]));
  a_r7_link_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !(phy_link_en && phy_glob_en) |-> !flags[3]);
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_flag_rd && !phy_link_evt) |=> (phy_flags[0] == 1'b0));
  a_r10_pkt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_count != '0 && host_clr[5]) |=> (flags[5] || pend_count == '0));
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_err_evt && host_clr[0]) |=> flags[0]);
endmodule

bind irq_flag_agg irq_flag_agg_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_err_evt(rx_err_evt), .tx_err_evt(tx_err_evt),
  .tx_req(tx_req), .phy_link_evt(phy_link_evt), .phy_flag_rd(phy_flag_rd),
  .phy_link_en(phy_link_en), .phy_glob_en(phy_glob_en), .host_clr(host_clr),
  .src_en(src_en), .glob_en(glob_en), .pend_count(pend_count), .flags(flags),
  .phy_flags(phy_flags), .int_n(int_n)
);

// File: tb/irq_flag_agg_test.sv
`timescale 1ns/1ps
module irq_flag_agg_test;
  localparam int CNT_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rx_err_evt = 0, tx_err_evt = 0, tx_req = 0, dma_busy = 0;
  logic [CNT_W-1:0] pend_count = '0;
  logic             phy_link_evt = 0, phy_flag_rd = 0, phy_link_en = 0, phy_glob_en = 0;
  logic [5:0]       host_set = '0, host_clr = '0, src_en = '0;
  logic             glob_en = 0;
  logic [5:0]       flags;
  logic [1:0]       phy_flags;
  logic             int_active, int_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  irq_flag_agg #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .rx_err_evt(rx_err_evt), .tx_err_evt(tx_err_evt),
    .tx_req(tx_req), .dma_busy(dma_busy), .pend_count(pend_count),
    .phy_link_evt(phy_link_evt), .phy_flag_rd(phy_flag_rd),
    .phy_link_en(phy_link_en), .phy_glob_en(phy_glob_en),
    .host_set(host_set), .host_clr(host_clr), .src_en(src_en), .glob_en(glob_en),
    .flags(flags), .phy_flags(phy_flags), .int_active(int_active), .int_n(int_n)
  );

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_all;
    host_clr = 6'h3F; phy_flag_rd = 1; pend_count = '0;
    tick;
    host_clr = '0; phy_flag_rd = 0;
  endtask

  initial begin
    repeat (3) tick;
    // R1 reset state
    chk("R1 flags", {2'b0, flags}, 8'h00);
    chk("R1 phy_flags", {6'b0, phy_flags}, 8'h00);
    chk("R1 int_n", {7'b0, int_n}, 8'h01);
    chk("R12 int_active reset", {7'b0, int_active}, 8'h00);
    rst_n = 1;
    tick;

    // sweep: all flag patterns x enable masks x global enable (R2, R12, R7, R10)
    phy_link_en = 1; phy_glob_en = 1;
    for (int p = 0; p < 64; p++) begin
      clear_all;
      host_set = 6'(p) & 6'b010111;
      phy_link_evt = p[3];
      pend_count = p[5] ? CNT_W'(p % 7 + 1) : '0;
      tick;
      host_set = '0; phy_link_evt = 0;
      tick;
      chk("R3 R7 R10 pattern", {2'b0, flags}, 8'(p));
      for (int g = 0; g < 2; g++) begin
        for (int m = 0; m < 64; m++) begin
          src_en = 6'(m); glob_en = g[0];
          tick;
          chk("R2 int_n", {7'b0, int_n}, {7'b0, !((g == 1) && ((p & m) != 0))});
          chk("R12 int_active", {7'b0, int_active}, {7'b0, ~int_n});
        end
      end
    end
    src_en = '0; glob_en = 0;
    clear_all; tick;

    // R2 release timing: clear last enabled flag, int_n high one cycle later
    src_en = 6'h01; glob_en = 1; rx_err_evt = 1; tick; rx_err_evt = 0;
    chk("R6 rx_err sets bit0", {2'b0, flags}, 8'h01);
    tick;
    chk("R2 int low", {7'b0, int_n}, 8'h00);
    host_clr = 6'h01; tick; host_clr = '0;
    chk("R3 cleared", {2'b0, flags}, 8'h00);
    chk("R2 int still low one cycle", {7'b0, int_n}, 8'h00);
    tick;
    chk("R2 int released", {7'b0, int_n}, 8'h01);
    src_en = '0; glob_en = 0;

    // R3 sticky hold
    host_set = 6'h10; tick; host_set = '0;
    repeat (5) tick;
    chk("R3 dma flag holds", {2'b0, flags}, 8'h10);
    clear_all;

    // R4 tx_req edges
    tx_req = 1; tick; tick;
    chk("R4 rise no set", {2'b0, flags}, 8'h00);
    tx_req = 0; tick;
    chk("R4 fall sets bit2", {2'b0, flags}, 8'h04);
    clear_all;

    // R5 dma_busy falling
    dma_busy = 1; tick; tick;
    chk("R5 rise no set", {2'b0, flags}, 8'h00);
    dma_busy = 0; tick;
    chk("R5 fall sets bit4", {2'b0, flags}, 8'h10);
    clear_all;

    // R6 tx_err sets both
    tx_err_evt = 1; tick; tx_err_evt = 0;
    chk("R6 tx_err bits1,2", {2'b0, flags}, 8'h06);
    clear_all;

    // R7 link gating with each enable combination
    phy_link_evt = 1; tick; phy_link_evt = 0;
    for (int e = 0; e < 4; e++) begin
      phy_link_en = e[0]; phy_glob_en = e[1];
      #1;
      chk("R7 link gate", {7'b0, flags[3]}, {7'b0, e == 3});
      chk("R7 phy_flags", {6'b0, phy_flags}, {6'b0, e == 3, 1'b1});
    end

    // R9 host access to link bit ignored
    host_clr = 6'h08; tick; host_clr = '0;
    chk("R9 host clr link ignored", {7'b0, flags[3]}, 8'h01);

    // R8 read clears
    phy_flag_rd = 1; tick; phy_flag_rd = 0;
    chk("R8 read clears link", {7'b0, flags[3]}, 8'h00);
    chk("R8 read clears phy flags", {6'b0, phy_flags}, 8'h00);
    host_set = 6'h08; tick; host_set = '0;
    chk("R9 host set link ignored", {2'b0, flags}, 8'h00);

    // R11 link: event and read together, set wins
    phy_link_evt = 1; phy_flag_rd = 1; tick; phy_link_evt = 0; phy_flag_rd = 0;
    chk("R11 link set wins", {6'b0, phy_flags}, 8'h03);
    clear_all;

    // R10 pending count, clear ignored
    pend_count = 4'd3; host_clr = 6'h20; tick; host_clr = '0;
    chk("R10 pkt held", {7'b0, flags[5]}, 8'h01);
    pend_count = 4'd0; #1;
    chk("R10 pkt zero", {7'b0, flags[5]}, 8'h00);
    host_set = 6'h20; tick; host_set = '0;
    chk("R10 host set ignored", {7'b0, flags[5]}, 8'h00);

    // R11 set wins over clear, each sticky source
    rx_err_evt = 1; tx_err_evt = 1; host_clr = 6'h3F; tick;
    rx_err_evt = 0; tx_err_evt = 0; host_clr = '0;
    chk("R11 event beats clear", {2'b0, flags}, 8'h07);
    dma_busy = 1; tick; dma_busy = 0; host_clr = 6'h10; tick; host_clr = '0;
    chk("R11 dma edge beats clear", {7'b0, flags[4]}, 8'h01);
    host_set = 6'h01; host_clr = 6'h01; clear_all;
    host_set = 6'h01; host_clr = 6'h01; tick; host_set = '0; host_clr = '0;
    chk("R11 host set beats clear", {7'b0, flags[0]}, 8'h01);

    // R1 reset clears everything
    src_en = 6'h3F; glob_en = 1; tick;
    rst_n = 0; tick;
    chk("R1 reset flags", {2'b0, flags}, 8'h00);
    chk("R1 reset int_n", {7'b0, int_n}, 8'h01);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule